// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 read lookup

This block is the read side of a first-level data cache. It begins a lookup as soon as the low twelve bits of an access are known. Those bits are the page offset, and translation never changes them. The block picks the cache set from bits 11:6 of that offset and captures every way of the set: tags, valid bits and line data. The physical page number comes back from translation a cycle or more later. The block then compares it against the captured tags, and only that compare waits on translation.

The geometry is 64 sets of 8 ways, with a 64-byte line in each way. The stored tag is the whole 40-bit physical page number. On a hit the block reports which way matched and returns the byte that the low six offset bits select.

A separate fill port writes a complete line and its tag into a set after a miss. It uses the lowest-numbered free way if the set has one, and a pseudo-random way if the set is full. Writes from the core, coherence and the next memory level are handled elsewhere.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset every way of every set is invalid, `busy` and `resp_valid` are low, and the first lookup misses.
- R2: `req_offset[11:6]` selects the set and `req_offset[5:0]` selects the byte inside the line. Byte k of a line is `fill_line[8k+7:8k]`.
- R3: A request (`req_valid` high while `busy` is low) is accepted at the clock edge. `busy` is high from the next cycle and stays high until the compare cycle, however many cycles translation takes.
- R4: The compare cycle is the first cycle in which `xlat_valid` is high while `busy` is high. In that cycle `resp_valid` and `hit` are valid without a further register. With no request outstanding, `xlat_valid` produces no response.
- R5: `busy` is low in the cycle after the compare cycle. A `req_valid` presented while `busy` is high is ignored and does not change the pending response.
- R6: A hit needs a valid way in the selected set whose tag equals all 40 bits of `xlat_ppn`. `hit_way` gives that way's number and `rdata` gives the selected byte of its line.
- R7: On a miss in the compare cycle, `hit` is 0 and `hit_way` and `rdata` are 0.
- R8: A fill writes the tag and the line into set `fill_index`, in the lowest-numbered invalid way, and marks that way valid. Filling 8 fresh tags into an empty set places them in ways 0 to 7 in order.
- R9: A fill into a full set replaces exactly one way, chosen by a free-running pseudo-random sequence. The new tag hits in the replaced way, and the other seven tags still hit.
- R10: Sets are independent. A tag filled into one set does not hit in a lookup of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Start a lookup with `req_offset` |
| req_offset | input | 12 | Untranslated page offset: set index in bits 11:6, byte in bits 5:0 |
| xlat_valid | input | 1 | Translation result present on `xlat_ppn` |
| xlat_ppn | input | 40 | Physical page number, used as the compare tag |
| fill_valid | input | 1 | Write one line this cycle |
| fill_index | input | 6 | Set to fill |
| fill_ppn | input | 40 | Tag stored with the filled line |
| fill_line | input | 512 | Line data, byte k in bits 8k+7:8k |
| busy | output | 1 | Lookup outstanding; new requests are ignored |
| resp_valid | output | 1 | Compare cycle |
| hit | output | 1 | Tag matched in a valid way |
| hit_way | output | 3 | Matching way |
| rdata | output | 8 | Addressed byte of the matching line |

## Verification
The lookups cover several cases. One probes the same set with tags held in different ways at the first, last and middle byte offsets, which separates a way-select fault from a byte-select fault. Another probes a tag that differs from a stored one only in its top bit, which shows whether all 40 bits are compared. A third probes the same tag in a set where it was never filled, which shows whether the set index takes part in the match. The delay between request and translation varies from zero to two cycles to show that `busy` holds over the wait. A request raised during the compare cycle must leave the response unchanged. Overfilling a full set must evict exactly one of nine tags, and the evicted tag must be the one whose way the newcomer took.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned RAND_W = 16;

  // Galois step, taps for x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [RAND_W-1:0] rand_step(input logic [RAND_W-1:0] s);
    logic [RAND_W-1:0] n;
    n = {1'b0, s[RAND_W-1:1]};
    if (s[0]) n = n ^ 16'hB400;
    return n;
  endfunction
endpackage

// File: rtl/vipt_rst_sync.sv
module vipt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/vipt_tag_cmp.sv
module vipt_tag_cmp #(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned PPN_W    = 40,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [PPN_W-1:0]    tags_i [NUM_WAYS],
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [PPN_W-1:0]    ppn_i,
  output logic [NUM_WAYS-1:0] match_o,
  output logic                any_o,
  output logic [WAY_W-1:0]    way_o
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign match_o[w] = valid_i[w] && (tags_i[w] == ppn_i);
  end

  assign any_o = |match_o;

  always_comb begin
    way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match_o[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vipt_victim_sel.sv
module vipt_victim_sel #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_ns,
  input  logic                advance_i,
  input  logic [NUM_WAYS-1:0] valid_row_i,
  output logic [WAY_W-1:0]    way_o
);
  import vipt_pkg::*;

  logic [RAND_W-1:0] rand_q, rand_d;
  logic [WAY_W-1:0]  free_way;
  logic              has_free;

  always_comb begin
    free_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_row_i[w]) free_way = WAY_W'(w);
    end
  end

  assign has_free = ~&valid_row_i;
  assign way_o    = has_free ? free_way : rand_q[WAY_W-1:0];
  assign rand_d   = advance_i ? rand_step(rand_q) : rand_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rand_q <= 16'h1ACE;
    else         rand_q <= rand_d;
  end

  p_free_way_first_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (advance_i && has_free) |-> !valid_row_i[way_o]);
  p_rand_alive_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    rand_q != '0);
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup #(
  parameter int unsigned NUM_SETS   = 64,
  parameter int unsigned NUM_WAYS   = 8,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned PPN_W      = 40,
  localparam int unsigned IDX_W     = $clog2(NUM_SETS),
  localparam int unsigned BOFF_W    = $clog2(LINE_BYTES),
  localparam int unsigned PGOFF_W   = IDX_W + BOFF_W,
  localparam int unsigned WAY_W     = $clog2(NUM_WAYS),
  localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [PGOFF_W-1:0] req_offset,
  input  logic               xlat_valid,
  input  logic [PPN_W-1:0]   xlat_ppn,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_index,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [LINE_W-1:0]  fill_line,
  output logic               busy,
  output logic               resp_valid,
  output logic               hit,
  output logic [WAY_W-1:0]   hit_way,
  output logic [7:0]         rdata
);
  logic rst_ns;

  vipt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  // storage arrays
  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [PPN_W-1:0]    tag_mem  [NUM_SETS][NUM_WAYS];
  logic [LINE_W-1:0]   line_mem [NUM_SETS][NUM_WAYS];

  // captured set
  logic                pend_q, pend_d;
  logic                accept;
  logic [PPN_W-1:0]    set_tag_q  [NUM_WAYS];
  logic [LINE_W-1:0]   set_line_q [NUM_WAYS];
  logic [NUM_WAYS-1:0] set_val_q;
  logic [BOFF_W-1:0]   boff_q;
  logic [IDX_W-1:0]    req_idx;

  // compare and fill
  logic [NUM_WAYS-1:0] match;
  logic                any_match;
  logic [WAY_W-1:0]    match_way;
  logic [WAY_W-1:0]    victim;
  logic [NUM_WAYS-1:0] fill_row_next;
  logic [LINE_W-1:0]   hit_line;

  assign req_idx = req_offset[PGOFF_W-1:BOFF_W];
  assign accept  = req_valid && !pend_q;

  always_comb begin
    pend_d = pend_q;
    if (accept)                    pend_d = 1'b1;
    else if (pend_q && xlat_valid) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  // set capture overlaps translation
  always_ff @(posedge clk) begin
    if (accept) begin
      set_val_q <= valid_q[req_idx];
      boff_q    <= req_offset[BOFF_W-1:0];
      for (int w = 0; w < NUM_WAYS; w++) begin
        set_tag_q[w]  <= tag_mem[req_idx][w];
        set_line_q[w] <= line_mem[req_idx][w];
      end
    end
  end

  vipt_tag_cmp #(.NUM_WAYS(NUM_WAYS), .PPN_W(PPN_W)) u_cmp (
    .tags_i (set_tag_q),
    .valid_i(set_val_q),
    .ppn_i  (xlat_ppn),
    .match_o(match),
    .any_o  (any_match),
    .way_o  (match_way)
  );

  assign busy       = pend_q;
  assign resp_valid = pend_q && xlat_valid;
  assign hit        = resp_valid && any_match;
  assign hit_way    = hit ? match_way : '0;
  assign hit_line   = set_line_q[match_way];
  assign rdata      = hit ? hit_line[{boff_q, 3'b000} +: 8] : 8'h00;

  // fill path
  vipt_victim_sel #(.NUM_WAYS(NUM_WAYS)) u_victim (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .advance_i  (fill_valid),
    .valid_row_i(valid_q[fill_index]),
    .way_o      (victim)
  );

  assign fill_row_next = valid_q[fill_index] | (NUM_WAYS'(1) << victim);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
    end else if (fill_valid) begin
      valid_q[fill_index] <= fill_row_next;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_mem[fill_index][victim]  <= fill_ppn;
      line_mem[fill_index][victim] <= fill_line;
    end
  end

  // checks
  p_accept_raises_busy_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && !busy) |=> busy);
  p_resp_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    resp_valid |-> busy);
  p_busy_drops_after_resp_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    resp_valid |=> !busy);
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    resp_valid |-> $onehot0(match));
  p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (resp_valid && !hit) |-> (rdata == 8'h00 && hit_way == '0));
  p_fill_marks_valid_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    fill_valid |=> valid_q[$past(fill_index)][$past(victim)]);
endmodule

// File: tb/vipt_l1_lookup_test.sv
module vipt_l1_lookup_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, xlat_valid, fill_valid;
  logic [11:0]  req_offset;
  logic [39:0]  xlat_ppn, fill_ppn;
  logic [5:0]   fill_index;
  logic [511:0] fill_line;
  logic         busy, resp_valid, hit;
  logic [2:0]   hit_way;
  logic [7:0]   rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  vipt_l1_lookup uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_offset(req_offset),
    .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
    .fill_valid(fill_valid), .fill_index(fill_index),
    .fill_ppn(fill_ppn), .fill_line(fill_line),
    .busy(busy), .resp_valid(resp_valid), .hit(hit),
    .hit_way(hit_way), .rdata(rdata)
  );

  localparam logic [39:0] TA = 40'h12_3456_7801;
  localparam logic [39:0] TB = 40'h9A_0000_4402;
  localparam logic [39:0] TC = 40'h03_FFFF_0003;
  localparam logic [39:0] TD = 40'h55_1234_0004;

  // {offset, ppn, exp_hit, exp_way}
  localparam int NV = 8;
  localparam logic [55:0] VEC [NV] = '{
    {6'd5, 6'd0,  TA,                     1'b1, 3'd0},
    {6'd5, 6'd63, TB,                     1'b1, 3'd1},
    {6'd5, 6'd17, TC,                     1'b1, 3'd2},
    {6'd5, 6'd4,  TD,                     1'b0, 3'd0},
    {6'd9, 6'd33, TA,                     1'b1, 3'd0},
    {6'd6, 6'd2,  TA,                     1'b0, 3'd0},
    {6'd9, 6'd1,  TB,                     1'b0, 3'd0},
    {6'd5, 6'd40, TA ^ 40'h80_0000_0000,  1'b0, 3'd0}
  };

  function automatic logic [7:0] bval(logic [39:0] t, int s, int k);
    return t[7:0] ^ t[39:32] ^ 8'(k * 7) ^ 8'(s * 13);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input int s, input logic [39:0] t);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_index = 6'(s);
    fill_ppn   = t;
    for (int k = 0; k < 64; k++) fill_line[8*k +: 8] = bval(t, s, k);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [11:0] off, input logic [39:0] ppn, input int gap,
                           output logic h, output logic [2:0] w, output logic [7:0] d);
    @(negedge clk);
    req_valid  = 1'b1;
    req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R3", "busy after accept", 64'(busy), 64'd1);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check(busy === 1'b1, "R3", "busy while waiting", 64'(busy), 64'd1);
    end
    xlat_valid = 1'b1;
    xlat_ppn   = ppn;
    #1;
    check(resp_valid === 1'b1, "R4", "resp in compare cycle", 64'(resp_valid), 64'd1);
    h = hit; w = hit_way; d = rdata;
    @(negedge clk);
    xlat_valid = 1'b0;
    check(busy === 1'b0, "R5", "busy cleared", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic       h;
    logic [2:0] w;
    logic [7:0] d;
    int         nhit;
    int         cway;

    rst_n = 1'b0; req_valid = 1'b0; xlat_valid = 1'b0; fill_valid = 1'b0;
    req_offset = '0; xlat_ppn = '0; fill_ppn = '0; fill_index = '0; fill_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(busy === 1'b0, "R1", "busy at reset", 64'(busy), 64'd0);
    check(resp_valid === 1'b0, "R1", "resp at reset", 64'(resp_valid), 64'd0);
    do_lookup({6'd5, 6'd0}, TA, 0, h, w, d);
    check(h === 1'b0, "R1", "hit on empty cache", 64'(h), 64'd0);

    // R8 fills fill free ways in order
    do_fill(5, TA); do_fill(5, TB); do_fill(5, TC);
    do_fill(9, TA);

    // table walk: R2 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      logic [11:0] off;
      logic [39:0] ppn;
      logic        eh;
      logic [2:0]  ew;
      logic [7:0]  ed;
      {off, ppn, eh, ew} = VEC[i];
      ed = eh ? bval(ppn, int'(off[11:6]), int'(off[5:0])) : 8'h00;
      do_lookup(off, ppn, i % 3, h, w, d);
      check(h === eh, "R6/R10", $sformatf("hit vec %0d", i), 64'(h), 64'(eh));
      check(w === ew, "R6/R7", $sformatf("way vec %0d", i), 64'(w), 64'(ew));
      check(d === ed, "R2/R7", $sformatf("byte vec %0d", i), 64'(d), 64'(ed));
    end

    // R5 request raised during compare cycle is ignored
    @(negedge clk);
    req_valid = 1'b1; req_offset = {6'd5, 6'd10};
    @(negedge clk);
    req_offset = {6'd5, 6'd63};
    xlat_valid = 1'b1; xlat_ppn = TB;
    #1;
    check(rdata === bval(TB, 5, 10), "R5", "byte of first request", 64'(rdata), 64'(bval(TB, 5, 10)));
    check(hit_way === 3'd1, "R5", "way of first request", 64'(hit_way), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b0, "R5", "second request not accepted", 64'(busy), 64'd0);
    #1;
    check(resp_valid === 1'b0, "R4", "translation with nothing pending", 64'(resp_valid), 64'd0);
    @(negedge clk);
    xlat_valid = 1'b0;

    // R8 eight fills land in ways 0..7
    for (int i = 0; i < 8; i++) do_fill(20, 40'h77_0000_0100 + 40'(i));
    for (int i = 0; i < 8; i++) begin
      do_lookup({6'd20, 6'(i)}, 40'h77_0000_0100 + 40'(i), 0, h, w, d);
      check(h === 1'b1 && w === 3'(i), "R8", $sformatf("way of fill %0d", i), 64'(w), 64'(i));
    end

    // R9 one replacement into a full set
    do_fill(20, TD);
    do_lookup({6'd20, 6'd7}, TD, 1, h, w, d);
    check(h === 1'b1, "R9", "new tag hits", 64'(h), 64'd1);
    check(d === bval(TD, 20, 7), "R9", "new line data", 64'(d), 64'(bval(TD, 20, 7)));
    cway = int'(w);
    nhit = 0;
    for (int i = 0; i < 8; i++) begin
      do_lookup({6'd20, 6'd0}, 40'h77_0000_0100 + 40'(i), 0, h, w, d);
      if (h) nhit++;
      if (i == cway) check(h === 1'b0, "R9", "replaced tag gone", 64'(h), 64'd0);
    end
    check(nhit == 7, "R9", "surviving tags", 64'(nhit), 64'd7);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule